// File: doc/BRIEF.md
# Multi-speed I2C SCL timing generator

This block produces the clock timing for an I2C master. It holds seven programmable cycle counts: a high-time and low-time pair for each of the standard, fast and high-speed classes, plus one SDA hold delay. Fast-plus operation uses the high-speed pair. At reset every count is loaded from the input clock frequency parameter: the cycle count is the clock rate in MHz times the minimum time in nanoseconds, divided by 1000.

While enabled and clocking, the generator drives SCL low for the low count, then releases it. It then waits until the synchronised SCL line reads high, so that a slave that holds the line low stretches the cycle. After that it counts the high time. It gives the bit engine four strobes: SCL fall, SDA change point (the hold count after the fall), SCL rise and a mid-high sample point. The speed class is taken from a two-bit request when a start is accepted, and it stays fixed until the next start.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset the block is idle: `scl_drive_low`, `busy`, `stretch` and all four strobes are 0, and `active_speed` reads 2 (fast).
- R2: With `CLK_MHZ`=100 the reset counts (high/low) are 400/470 for standard, 60/130 for fast and 6/16 for high-speed, and the hold count is 30.
- R3: A start accepted with `speed_req` 1, 2 or 3 selects standard, fast or high-speed counts and `active_speed` shows that code. A `speed_req` of 0 selects fast (code 2).
- R4: A write with `cfg_wr` high and `cfg_sel` 0..6 (0 standard high, 1 standard low, 2 fast high, 3 fast low, 4 high-speed high, 5 high-speed low, 6 hold) loads `cfg_wdata`. A write with data zero leaves the old value in place.
- R5: Each low phase keeps `scl_drive_low` high for exactly max(low count, 3) cycles, and `fall_stb` marks its first cycle.
- R6: The high phase does not start until the synchronised SCL reads high. From the `rise_stb` cycle it lasts exactly max(high count, 1) cycles before the next `fall_stb`.
- R7: `sda_chg_stb` fires exactly H cycles after `fall_stb`, where H is the hold count clamped to at most the effective low count minus 2.
- R8: `sample_stb` fires floor(effective high count / 2) cycles after `rise_stb`.
- R9: A `start_req` while `busy` is ignored. `active_speed` and the counts in use change only at a start accepted while idle.
- R10: When `en` is low, the block goes idle on the next clock edge and releases SCL.
- R11: `stretch` is high only while SCL is released, the synchronised line is still low, and the wait has passed the synchroniser latency. It never rises in an unstretched bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Count register write strobe |
| cfg_sel | input | 3 | Count register select (see R4) |
| cfg_wdata | input | CNT_W | Count value to write |
| speed_req | input | 2 | Requested speed class, taken at start |
| en | input | 1 | Clocking enable; low forces idle |
| start_req | input | 1 | Begin clocking (accepted only when idle) |
| scl_in | input | 1 | SCL line as seen on the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| fall_stb | output | 1 | First cycle of a low phase |
| sda_chg_stb | output | 1 | SDA may change now |
| rise_stb | output | 1 | First cycle of a counted high phase |
| sample_stb | output | 1 | Sample SDA now |
| stretch | output | 1 | Slave is holding SCL low |
| busy | output | 1 | Generator is clocking |
| active_speed | output | 2 | Speed code in use |

## Verification
The bound checker checks on every cycle the properties that need only the current and previous cycle. A fall is always driven low and never coincides with a rise. A rise follows a cycle with SCL released. SDA changes only inside the low phase. `stretch` implies SCL is released. The block is idle after `en` drops. The speed code changes only out of idle. The exact phase lengths, hold and sample offsets, the reset counts, the ignored zero writes, the minimum-count clamps and the ignored restart while busy can only be shown by the bench. Its scoreboard measures each bit period under the speed classes, register settings and slave stretching it applies.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

   // Speed request / active speed codes
   typedef enum logic [1:0] {
      SPD_NONE = 2'd0,
      SPD_STD  = 2'd1,
      SPD_FAST = 2'd2,
      SPD_HIGH = 2'd3
   } speed_e;

   // Count register selectors
   localparam int unsigned SEL_STD_HI  = 0;
   localparam int unsigned SEL_STD_LO  = 1;
   localparam int unsigned SEL_FAST_HI = 2;
   localparam int unsigned SEL_FAST_LO = 3;
   localparam int unsigned SEL_HIGH_HI = 4;
   localparam int unsigned SEL_HIGH_LO = 5;
   localparam int unsigned SEL_HOLD    = 6;
   localparam int unsigned NUM_REGS    = 7;

   // Phase of the SCL cycle
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } phase_e;

   // Minimum times in ns for each register slot; the high-speed slot
   // holds either true high-speed or fast-plus values.
   function automatic int unsigned slot_ns(int unsigned slot, bit fast_plus);
      case (slot)
         SEL_STD_HI:  return 4000;
         SEL_STD_LO:  return 4700;
         SEL_FAST_HI: return 600;
         SEL_FAST_LO: return 1300;
         SEL_HIGH_HI: return fast_plus ? 260 : 60;
         SEL_HIGH_LO: return fast_plus ? 500 : 160;
         default:     return 300;
      endcase
   endfunction

   // Cycles for a time at a clock rate: MHz * ns / 1000
   function automatic int unsigned ns_to_cycles(int unsigned mhz, int unsigned ns);
      return (mhz * ns) / 1000;
   endfunction

endpackage

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else if (STAGES == 1) pipe <= d;
            else pipe <= {pipe[STAGES-2:0], d};
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_scl_cfg_regs.sv
module i2c_scl_cfg_regs
   import i2c_scl_pkg::*;
#(
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned CLK_MHZ      = 100,
   parameter bit          HS_FAST_PLUS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [2:0]       sel,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] std_hi,
   output logic [CNT_W-1:0] std_lo,
   output logic [CNT_W-1:0] fast_hi,
   output logic [CNT_W-1:0] fast_lo,
   output logic [CNT_W-1:0] high_hi,
   output logic [CNT_W-1:0] high_lo,
   output logic [CNT_W-1:0] hold
);
   logic [CNT_W-1:0] slot_q [NUM_REGS];
   logic             wr_nz;

   assign wr_nz = wr && (wdata != '0);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
         localparam int unsigned RST_CYC = ns_to_cycles(CLK_MHZ, slot_ns(i, HS_FAST_PLUS));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q[i] <= CNT_W'(RST_CYC);
            else if (wr_nz && (sel == 3'(i)))
               slot_q[i] <= wdata;
         end
      end
   endgenerate

   assign std_hi  = slot_q[SEL_STD_HI];
   assign std_lo  = slot_q[SEL_STD_LO];
   assign fast_hi = slot_q[SEL_FAST_HI];
   assign fast_lo = slot_q[SEL_FAST_LO];
   assign high_hi = slot_q[SEL_HIGH_HI];
   assign high_lo = slot_q[SEL_HIGH_LO];
   assign hold    = slot_q[SEL_HOLD];
endmodule

// File: rtl/i2c_scl_speed_sel.sv
module i2c_scl_speed_sel
   import i2c_scl_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned MIN_LO = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [1:0]       speed_req,
   input  logic [CNT_W-1:0] std_hi,
   input  logic [CNT_W-1:0] std_lo,
   input  logic [CNT_W-1:0] fast_hi,
   input  logic [CNT_W-1:0] fast_lo,
   input  logic [CNT_W-1:0] high_hi,
   input  logic [CNT_W-1:0] high_lo,
   input  logic [CNT_W-1:0] hold,
   output logic [1:0]       active_speed,
   output logic [CNT_W-1:0] hi_eff,
   output logic [CNT_W-1:0] lo_eff,
   output logic [CNT_W-1:0] hold_eff,
   output logic [CNT_W-1:0] samp_pt
);
   localparam logic [CNT_W-1:0] LO_FLOOR   = CNT_W'(MIN_LO);
   localparam logic [CNT_W-1:0] HOLD_SLACK = CNT_W'(2);

   speed_e           spd_q;
   speed_e           spd_req_dec;
   logic [CNT_W-1:0] hi_raw, lo_raw, hold_cap;

   assign spd_req_dec = (speed_req == SPD_NONE) ? SPD_FAST : speed_e'(speed_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    spd_q <= SPD_FAST;
      else if (load) spd_q <= spd_req_dec;
   end

   always_comb begin
      case (spd_q)
         SPD_STD:  begin hi_raw = std_hi;  lo_raw = std_lo;  end
         SPD_HIGH: begin hi_raw = high_hi; lo_raw = high_lo; end
         default:  begin hi_raw = fast_hi; lo_raw = fast_lo; end
      endcase
   end

   assign lo_eff   = (lo_raw < LO_FLOOR) ? LO_FLOOR : lo_raw;
   assign hi_eff   = (hi_raw == '0) ? CNT_W'(1) : hi_raw;
   assign hold_cap = lo_eff - HOLD_SLACK;
   assign hold_eff = (hold > hold_cap) ? hold_cap : hold;
   assign samp_pt  = (hi_eff >> 1) + CNT_W'(1);

   assign active_speed = spd_q;
endmodule

// File: rtl/i2c_scl_phase_fsm.sv
module i2c_scl_phase_fsm
   import i2c_scl_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start_req,
   input  logic             scl_s,
   input  logic [CNT_W-1:0] hi_eff,
   input  logic [CNT_W-1:0] lo_eff,
   input  logic [CNT_W-1:0] hold_eff,
   input  logic [CNT_W-1:0] samp_pt,
   output logic             start_ok,
   output logic             scl_drive_low,
   output logic             fall_stb,
   output logic             sda_chg_stb,
   output logic             rise_stb,
   output logic             sample_stb,
   output logic             stretch,
   output logic             busy
);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
   localparam logic [CNT_W-1:0] SYNC_LAT = CNT_W'(SYNC_STAGES);

   phase_e           ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   chg_pt;

   assign start_ok = (ph_q == PH_IDLE) && en && start_req;
   assign chg_pt   = {1'b0, hold_eff} + {{CNT_W{1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else if (!en) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               if (start_req) begin
                  ph_q  <= PH_LOW;
                  cnt_q <= ONE;
               end
            end
            PH_LOW: begin
               if (cnt_q >= lo_eff) begin
                  ph_q  <= PH_WAIT;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            PH_WAIT: begin
               if (scl_s) begin
                  ph_q  <= PH_HIGH;
                  cnt_q <= ONE;
               end else if (cnt_q != '1) begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            default: begin
               if (cnt_q >= hi_eff) begin
                  ph_q  <= PH_LOW;
                  cnt_q <= ONE;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
         endcase
      end
   end

   assign scl_drive_low = (ph_q == PH_LOW);
   assign fall_stb      = (ph_q == PH_LOW)  && (cnt_q == ONE);
   assign sda_chg_stb   = (ph_q == PH_LOW)  && ({1'b0, cnt_q} == chg_pt);
   assign rise_stb      = (ph_q == PH_HIGH) && (cnt_q == ONE);
   assign sample_stb    = (ph_q == PH_HIGH) && (cnt_q == samp_pt);
   assign stretch       = (ph_q == PH_WAIT) && !scl_s && (cnt_q >= SYNC_LAT);
   assign busy          = (ph_q != PH_IDLE);
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
   import i2c_scl_pkg::*;
#(
   parameter int unsigned CLK_MHZ      = 100,
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          HS_FAST_PLUS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [2:0]       cfg_sel,
   input  logic [CNT_W-1:0] cfg_wdata,
   input  logic [1:0]       speed_req,
   input  logic             en,
   input  logic             start_req,
   input  logic             scl_in,
   output logic             scl_drive_low,
   output logic             fall_stb,
   output logic             sda_chg_stb,
   output logic             rise_stb,
   output logic             sample_stb,
   output logic             stretch,
   output logic             busy,
   output logic [1:0]       active_speed
);
   localparam int unsigned MIN_LO      = 3;
   localparam int unsigned LONGEST_CYC = ns_to_cycles(CLK_MHZ, slot_ns(SEL_STD_LO, 1'b0));

   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("CNT_W must be at least 4");
      end
      if (LONGEST_CYC >= (64'd1 << CNT_W)) begin : g_bad_range
         $error("CNT_W too narrow for default counts at CLK_MHZ");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic [CNT_W-1:0] std_hi, std_lo, fast_hi, fast_lo, high_hi, high_lo, hold;
   logic [CNT_W-1:0] hi_eff, lo_eff, hold_eff, samp_pt;
   logic             scl_s;
   logic             start_ok;

   i2c_scl_cfg_regs #(
      .CNT_W(CNT_W), .CLK_MHZ(CLK_MHZ), .HS_FAST_PLUS(HS_FAST_PLUS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
      .std_hi(std_hi), .std_lo(std_lo), .fast_hi(fast_hi), .fast_lo(fast_lo),
      .high_hi(high_hi), .high_lo(high_lo), .hold(hold)
   );

   i2c_scl_speed_sel #(
      .CNT_W(CNT_W), .MIN_LO(MIN_LO)
   ) u_speed (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .speed_req(speed_req),
      .std_hi(std_hi), .std_lo(std_lo), .fast_hi(fast_hi), .fast_lo(fast_lo),
      .high_hi(high_hi), .high_lo(high_lo), .hold(hold),
      .active_speed(active_speed), .hi_eff(hi_eff), .lo_eff(lo_eff),
      .hold_eff(hold_eff), .samp_pt(samp_pt)
   );

   i2c_scl_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
   );

   i2c_scl_phase_fsm #(
      .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(en), .start_req(start_req), .scl_s(scl_s),
      .hi_eff(hi_eff), .lo_eff(lo_eff), .hold_eff(hold_eff), .samp_pt(samp_pt),
      .start_ok(start_ok), .scl_drive_low(scl_drive_low), .fall_stb(fall_stb),
      .sda_chg_stb(sda_chg_stb), .rise_stb(rise_stb), .sample_stb(sample_stb),
      .stretch(stretch), .busy(busy)
   );
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic       scl_drive_low,
   input logic       fall_stb,
   input logic       sda_chg_stb,
   input logic       rise_stb,
   input logic       sample_stb,
   input logic       stretch,
   input logic       busy,
   input logic [1:0] active_speed
);
   assert_fall_drives_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> scl_drive_low);

   assert_rise_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> (!scl_drive_low && !$past(scl_drive_low) && !fall_stb));

   assert_change_in_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sda_chg_stb |-> scl_drive_low);

   assert_sample_in_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (!scl_drive_low && busy));

   assert_speed_only_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_speed != $past(active_speed)) |-> !$past(busy));

   assert_speed_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active_speed != 2'd0);

   assert_idle_after_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (!busy && !scl_drive_low));

   assert_stretch_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stretch |-> (!scl_drive_low && busy));
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .scl_drive_low(scl_drive_low),
   .fall_stb(fall_stb), .sda_chg_stb(sda_chg_stb), .rise_stb(rise_stb),
   .sample_stb(sample_stb), .stretch(stretch), .busy(busy),
   .active_speed(active_speed)
);

// File: tb/sim_i2c_scl_timer.sv
module sim_i2c_scl_timer;
   localparam int CNT_W = 16;

   typedef struct {
      int    lo;
      int    hi;
      int    hold;
      int    samp;
      string tag;
   } bit_exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_wr = 1'b0;
   logic [2:0]       cfg_sel = '0;
   logic [CNT_W-1:0] cfg_wdata = '0;
   logic [1:0]       speed_req = '0;
   logic             en = 1'b1;
   logic             start_req = 1'b0;
   logic             slave_low = 1'b0;
   logic             scl_in;
   logic             scl_drive_low, fall_stb, sda_chg_stb, rise_stb, sample_stb;
   logic             stretch, busy;
   logic [1:0]       active_speed;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit stretch_arm = 1'b0;
   int stretch_cnt = 0;
   bit_exp_t exp_q[$];

   always #4 clk = ~clk;

   assign scl_in = !scl_drive_low && !slave_low;

   i2c_scl_timer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .speed_req(speed_req), .en(en),
      .start_req(start_req), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
      .fall_stb(fall_stb), .sda_chg_stb(sda_chg_stb), .rise_stb(rise_stb),
      .sample_stb(sample_stb), .stretch(stretch), .busy(busy),
      .active_speed(active_speed)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Monitor: measure each bit period and compare with the scoreboard
   bit in_bit = 0, seen_rise = 0;
   int t_fall = 0, t_rise = 0, m_lo = 0, m_hi = 0, m_hold = -1, m_samp = -1;

   always @(negedge clk) begin
      if (stretch) stretch_cnt++;
      if (fall_stb) begin
         if (in_bit && seen_rise) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 unexpected bit", m_lo, 0);
            end else begin
               bit_exp_t e;
               e = exp_q.pop_front();
               chk(m_lo == e.lo,     {e.tag, " R5 low length"},  m_lo,   e.lo);
               chk(m_hi == e.hi,     {e.tag, " R6 high length"}, m_hi,   e.hi);
               chk(m_hold == e.hold, {e.tag, " R7 hold offset"}, m_hold, e.hold);
               chk(m_samp == e.samp, {e.tag, " R8 sample offset"}, m_samp, e.samp);
            end
         end
         in_bit = 1; seen_rise = 0; t_fall = 0; m_lo = 0; m_hi = 0;
         m_hold = -1; m_samp = -1;
      end
      if (in_bit) begin
         if (scl_drive_low) m_lo++;
         if (sda_chg_stb) m_hold = t_fall;
         if (rise_stb) begin seen_rise = 1; t_rise = 0; end
         if (seen_rise) begin
            m_hi++;
            if (sample_stb) m_samp = t_rise;
            t_rise++;
         end
         t_fall++;
      end
   end

   // Slave model: holds SCL low for 20 cycles past the master's release
   initial begin
      forever begin
         @(negedge clk);
         if (stretch_arm && scl_drive_low) begin
            slave_low = 1'b1;
            while (scl_drive_low) @(negedge clk);
            repeat (20) @(negedge clk);
            slave_low = 1'b0;
            stretch_arm = 1'b0;
         end
      end
   end

   task automatic cfg_write(input int sel, input int val);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = 3'(sel); cfg_wdata = CNT_W'(val);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // Driver: push expected bits, start, wait for them, then stop with en
   task automatic run_bits(input int spd, input int nbits, input int lo, input int hi,
                           input int hold, input string tag, input bit restart_mid);
      int lo_e, hi_e, hold_e;
      lo_e   = (lo < 3) ? 3 : lo;
      hi_e   = (hi < 1) ? 1 : hi;
      hold_e = (hold > lo_e - 2) ? lo_e - 2 : hold;
      for (int i = 0; i < nbits; i++)
         exp_q.push_back('{lo_e, hi_e, hold_e, hi_e / 2, tag});
      @(negedge clk);
      speed_req = 2'(spd);
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      if (restart_mid) begin
         while (exp_q.size() == nbits) @(negedge clk);
         speed_req = 2'd1;
         start_req = 1'b1;
         @(negedge clk);
         start_req = 1'b0;
      end
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      chk(scl_drive_low == 1'b1, "R10 precondition low", scl_drive_low, 1);
      en = 1'b0;
      @(negedge clk);
      chk(scl_drive_low == 1'b0 && busy == 1'b0, "R10 idle after disable",
          {scl_drive_low, busy}, 0);
      en = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(scl_drive_low == 0, "R1 scl released", scl_drive_low, 0);
      chk({fall_stb, sda_chg_stb, rise_stb, sample_stb} == 0, "R1 strobes",
          {fall_stb, sda_chg_stb, rise_stb, sample_stb}, 0);
      chk(busy == 0 && stretch == 0, "R1 busy/stretch", {busy, stretch}, 0);
      chk(active_speed == 2, "R1 speed code", active_speed, 2);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy == 0, "R1 idle after reset", busy, 0);

      // R2/R3: no request means fast with default counts
      run_bits(0, 2, 130, 60, 30, "R2 fast default", 1'b0);
      chk(active_speed == 2, "R3 none selects fast", active_speed, 2);
      chk(stretch_cnt == 0, "R11 no stretch unstretched", stretch_cnt, 0);

      run_bits(1, 2, 470, 400, 30, "R2 standard default", 1'b0);
      chk(active_speed == 1, "R3 standard code", active_speed, 1);

      // R7: default hold 30 clamped to low 16 minus 2
      run_bits(3, 2, 16, 6, 30, "R7 high-speed hold clamp", 1'b0);
      chk(active_speed == 3, "R3 high-speed code", active_speed, 3);

      // R4: zero write ignored, nonzero writes land
      cfg_write(3, 0);
      cfg_write(2, 25);
      cfg_write(6, 5);
      run_bits(2, 2, 130, 25, 5, "R4 zero write kept", 1'b0);

      // R9: start while busy ignored
      run_bits(2, 3, 130, 25, 5, "R9 restart ignored", 1'b1);
      chk(active_speed == 2, "R9 speed unchanged while busy", active_speed, 2);
      run_bits(1, 1, 470, 400, 5, "R9 next start standard", 1'b0);
      chk(active_speed == 1, "R9 speed taken at next start", active_speed, 1);

      // R5/R6/R8 minimum clamps
      cfg_write(5, 1);
      cfg_write(4, 1);
      run_bits(3, 2, 1, 1, 5, "R5 R6 R8 minimum counts", 1'b0);

      // R11 clock stretching: high time unchanged, stretch flagged
      stretch_cnt = 0;
      stretch_arm = 1'b1;
      run_bits(2, 2, 130, 25, 5, "R6 stretched bit", 1'b0);
      chk(stretch_cnt >= 18 && stretch_cnt <= 22, "R11 stretch cycles", stretch_cnt, 20);

      chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule